// File: doc/BRIEF.md
# Walsh Function Wave Generator

The block produces every Walsh function of a chosen order N at once, as 2^N parallel bit-streams. Output bit k carries Walsh function k, read over time as row k of the naturally ordered (Sylvester) Hadamard matrix, with +1 shown as logic 1 and -1 as logic 0. One column of the matrix, which is one sample of every waveform, is presented per accepted transfer. A full period is 2^N samples long.

The only state is an N-bit down counter. Each output bit is the inverted parity of a fixed subset of the counter's elapsed-step bits, so row 0 is constant logic 1. The sample stream leaves through a valid/ready port. `en` starts the stream. While `out_valid` is high and `out_ready` is low, the counter does not move, and the sample and its start-of-period flag stay unchanged. The stream advances only on a rising clock edge where `out_valid` and `out_ready` are both high.

Top module: `walsh_wave_gen`

## Requirements
- R1: A synchronous active-high reset `rst` sets the period step to 0, so the first sample of every waveform is 1 (`walsh_o` is all ones). This also applies to a reset in the middle of a period.
- R2: `walsh_o[0]` is 1 in every cycle.
- R3: At period step t, `walsh_o[k]` is 1 when the count of bits set in (k AND t) is even and 0 when it is odd. This equals row k, column t of the Sylvester Hadamard matrix of order N.
- R4: Each rising edge with `out_valid` and `out_ready` both high advances the step by one. After step 2^N-1 the step returns to 0.
- R5: While `out_valid` is high and `out_ready` is low, `walsh_o` and `sync_o` hold their values and the step does not change.
- R6: While `en` is low, the step does not change.
- R7: `out_valid` follows `en` in the same cycle.
- R8: `sync_o` is high exactly when `out_valid` is high and the step is 0. It marks the first sample of each period.
- R9: Over one period, row 0 holds 2^N ones and every other row holds exactly 2^(N-1) ones. At every step other than 0, exactly half of the output bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per accepted transfer |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Starts the stream; drives `out_valid` |
| out_ready | input | 1 | Downstream accepts the current sample |
| out_valid | output | 1 | The current sample is offered |
| walsh_o | output | 2^N | Bit k is Walsh function k at the current step |
| sync_o | output | 1 | High on the first sample of each period while valid |

## Verification
`walsh_o`, `out_valid` and `sync_o` are combinational from the counter and `en`. A new sample therefore appears right after the single rising edge that accepts a transfer, and a reset takes effect at the first edge where it is sampled. The bench drives its inputs and samples the outputs at the falling edge, one full edge after each stimulus. It keeps its own step index, advancing that index only for edges where it drove both `en` and `out_ready` high. It compares every sample against a Hadamard matrix that it builds itself by repeated doubling.

// File: rtl/walsh_pkg.sv
package walsh_pkg;
  // Inverted parity of a masked vector: 1 when an even number of bits are set.
  function automatic logic even_parity(input logic [15:0] v);
    return ~^v;
  endfunction
endpackage

// File: rtl/walsh_step_counter.sv
module walsh_step_counter #(
  parameter int ORDER = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [ORDER-1:0] step,
  output logic             at_first
);
  logic [ORDER-1:0] cnt_q;

  // Down counter: reset to all ones means elapsed step 0.
  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '1;
    else if (advance) cnt_q <= cnt_q - 1'b1;
  end

  assign step     = ~cnt_q;
  assign at_first = &cnt_q;

  // R4: after the last step of a period an accepted transfer returns to step 0
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (advance && (cnt_q == '0)) |=> at_first);

  // R6: without an advance the step holds
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(step));
endmodule

// File: rtl/walsh_row_decoder.sv
module walsh_row_decoder
  import walsh_pkg::*;
#(
  parameter int ORDER = 3,
  localparam int NUM  = 1 << ORDER
) (
  input  logic [ORDER-1:0] step,
  output logic [NUM-1:0]   rows
);
  generate
    for (genvar k = 0; k < NUM; k++) begin : g_row
      if (k == 0) begin : g_const
        assign rows[k] = 1'b1;
      end else begin : g_xor
        localparam logic [ORDER-1:0] MASK = ORDER'(k);
        assign rows[k] = even_parity(16'(MASK & step));
      end
    end
  endgenerate
endmodule

// File: rtl/walsh_wave_gen.sv
module walsh_wave_gen #(
  parameter int ORDER = 3,
  localparam int NUM  = 1 << ORDER,
  localparam int HALF = NUM / 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           out_ready,
  output logic           out_valid,
  output logic [NUM-1:0] walsh_o,
  output logic           sync_o
);
  logic [ORDER-1:0] step;
  logic             at_first;
  logic             fire;

  assign out_valid = en;
  assign fire      = out_valid & out_ready;

  walsh_step_counter #(.ORDER(ORDER)) u_cnt (
    .clk(clk), .rst(rst), .advance(fire), .step(step), .at_first(at_first)
  );

  walsh_row_decoder #(.ORDER(ORDER)) u_dec (
    .step(step), .rows(walsh_o)
  );

  assign sync_o = out_valid & at_first;

  // R5: a stalled sample and its flag stay put
  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(walsh_o) && $stable(at_first)));

  // R8: the period-start flag coincides with the all-ones column
  a_r8_sync_start: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> (&walsh_o));

  // R9: every column other than the first is balanced
  a_r9_balance: assert property (@(posedge clk) disable iff (rst)
    !(&walsh_o) |-> ($countones(walsh_o) == HALF));

  // R2: row 0 never drops
  a_r2_row0_high: assert property (@(posedge clk) disable iff (rst)
    walsh_o[0]);
endmodule

// File: tb/walsh_wave_gen_test.sv
module walsh_wave_gen_test;
  localparam int ORDER = 4;
  localparam int NUM   = 1 << ORDER;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           en = 1'b0;
  logic           out_ready = 1'b0;
  logic           out_valid;
  logic [NUM-1:0] walsh_o;
  logic           sync_o;

  int n_run = 0;
  int n_fail = 0;
  int t_exp = 0;
  bit done = 1'b0;
  logic hm [NUM][NUM];

  always #2 clk = ~clk;

  walsh_wave_gen #(.ORDER(ORDER)) uut (
    .clk(clk), .rst(rst), .en(en), .out_ready(out_ready),
    .out_valid(out_valid), .walsh_o(walsh_o), .sync_o(sync_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [NUM-1:0] column(input int t);
    logic [NUM-1:0] c;
    for (int r = 0; r < NUM; r++) c[r] = hm[r][t];
    return c;
  endfunction

  // Drive at falling edge, let one rising edge act, return at the next falling edge.
  task automatic tick(input logic e, input logic rdy, input logic r = 1'b0);
    en = e; out_ready = rdy; rst = r;
    @(posedge clk);
    if (r) t_exp = 0;
    else if (e && rdy) t_exp = (t_exp + 1) % NUM;
    @(negedge clk);
  endtask

  task automatic check_sample(input string tag);
    check({tag, " R3 column"}, 64'(walsh_o), 64'(column(t_exp)));
    check({tag, " R2 row0"}, 64'(walsh_o[0]), 64'd1);
    check({tag, " R7 valid"}, 64'(out_valid), 64'(en));
    check({tag, " R8 sync"}, 64'(sync_o), 64'(en && t_exp == 0));
  endtask

  task automatic t_reset();
    tick(1'b0, 1'b0, 1'b1);
    tick(1'b0, 1'b0);
    check("R1 reset ones", 64'(walsh_o), 64'(column(0)));
    check("R7 valid low", 64'(out_valid), 64'd0);
    check("R8 no sync idle", 64'(sync_o), 64'd0);
  endtask

  task automatic t_full_periods();
    en = 1'b1; out_ready = 1'b1;
    #0;
    check_sample("R4 start");
    for (int i = 0; i < 2 * NUM + 3; i++) begin
      tick(1'b1, 1'b1);
      check_sample("R4 stream");
    end
  endtask

  task automatic t_stall();
    logic [NUM-1:0] held;
    logic hs;
    int tk;
    tick(1'b1, 1'b0);
    held = walsh_o; hs = sync_o; tk = t_exp;
    for (int i = 0; i < 5; i++) begin
      tick(1'b1, 1'b0);
      check("R5 data held", 64'(walsh_o), 64'(held));
      check("R5 sync held", 64'(sync_o), 64'(hs));
    end
    check("R5 step held", 64'(t_exp), 64'(tk));
    tick(1'b1, 1'b1);
    check_sample("R5 resume");
  endtask

  task automatic t_idle();
    int tk;
    tk = t_exp;
    for (int i = 0; i < 4; i++) begin
      tick(1'b0, 1'b1);
      check("R6 idle column", 64'(walsh_o), 64'(column(tk)));
      check("R7 idle valid", 64'(out_valid), 64'd0);
    end
  endtask

  task automatic t_mixed_ready();
    for (int i = 0; i < 3 * NUM; i++) begin
      tick(1'b1, 1'((i % 3) != 1));
      check_sample("R4 mixed");
    end
  endtask

  task automatic t_balance();
    int ones [NUM];
    for (int r = 0; r < NUM; r++) ones[r] = 0;
    while (t_exp != 0) tick(1'b1, 1'b1);
    for (int i = 0; i < NUM; i++) begin
      for (int r = 0; r < NUM; r++) ones[r] += int'(walsh_o[r]);
      tick(1'b1, 1'b1);
    end
    for (int r = 0; r < NUM; r++)
      check("R9 row ones", 64'(ones[r]), 64'(r == 0 ? NUM : NUM / 2));
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1);
    tick(1'b1, 1'b1, 1'b1);
    en = 1'b1; #0;
    check("R1 mid reset ones", 64'(walsh_o), 64'(column(0)));
    check("R1 mid reset sync", 64'(sync_o), 64'd1);
    tick(1'b1, 1'b1);
    check_sample("R1 after reset");
  endtask

  initial begin
    // Sylvester construction by doubling
    hm[0][0] = 1'b1;
    for (int s = 1; s < NUM; s = s * 2)
      for (int r = 0; r < s; r++)
        for (int c = 0; c < s; c++) begin
          hm[r][c + s]     = hm[r][c];
          hm[r + s][c]     = hm[r][c];
          hm[r + s][c + s] = ~hm[r][c];
        end
    @(negedge clk);
    t_reset();
    t_full_periods();
    t_stall();
    t_idle();
    t_mixed_ready();
    t_balance();
    t_reset_mid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule